// File: doc/BRIEF.md
# Cache Range Maintenance Engine

This block drives maintenance requests into the tag and state port of a physically indexed second-level cache. A requester issues commands on a single command port. A range operation takes two commands. The first loads a start address into a start register; each range kind has its own start register. The second supplies the end address and launches a walk. The walk visits every cache line whose base address lies inside the inclusive window from start to end, moving upward in 32-byte steps.

For each line, the engine raises a request on the tag port with a kind code and an address. It holds both until the port acknowledges. Three single-line commands are also accepted: clean, invalidate, and clean-then-invalidate. An invalidate-all command walks every set/way index in ascending order. The stall output stays high for as long as any walk runs. A range that is malformed produces a one-cycle error pulse and no line traffic. A range is malformed when the end is below the start, when the two addresses lie in different 4 KiB pages, or when no line base falls inside the window.

Top module: `cme_engine`

## Requirements
- R1: After reset, stall_o, tag_req_o and err_o are all low.
- R2: Command codes on cmd_op_i are: 0 clean-range start, 1 clean-range end, 2 invalidate-range start, 3 invalidate-range end, 4 clean line, 5 invalidate line, 6 clean-then-invalidate line, 7 invalidate all. A start command alone produces no request, no stall and no error. Only the matching end command launches a walk.
- R3: A range walk issues one request for every line whose base address (a multiple of 32) lies in [start, end], in ascending order. Kind code 0 is used for clean ranges and kind code 1 for invalidate ranges. Each kind uses the start address last written with its own start command.
- R4: stall_o and tag_req_o rise in the cycle after an accepted launching command. They fall in the cycle after the acknowledge of the final request.
- R5: A request keeps its address and kind until tag_ack_i is seen high at a clock edge. The next request follows only after that acknowledge.
- R6: Single-line commands issue exactly one request at the command address with bits [4:0] cleared. Clean uses kind 0, invalidate uses kind 1, and clean-then-invalidate uses kind 2.
- R7: Invalidate-all issues kind-3 requests whose tag_addr_o carries the set/way index, from 0 up to NUM_SETS*NUM_WAYS-1.
- R8: A range end command is rejected in three cases: end < start, address bits [31:12] differ between start and end, or the window holds no line base. A rejected command produces no request, and stall_o stays low. err_o is high for exactly the following cycle.
- R9: Commands presented while stall_o is high are ignored. This includes a command in the same cycle as the final acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code (see R2) |
| cmd_addr_i | input | ADDR_W | Command address |
| stall_o | output | 1 | Requester stall, high while a walk runs |
| err_o | output | 1 | One-cycle rejection pulse for a malformed range |
| tag_req_o | output | 1 | Tag port request |
| tag_kind_o | output | 2 | Request kind: 0 clean, 1 invalidate, 2 clean+invalidate, 3 invalidate by index |
| tag_addr_o | output | ADDR_W | Line address, or set/way index for kind 3 |
| tag_ack_i | input | 1 | Tag port acknowledge |

## Verification
Two events can land on the same clock edge: the acknowledge that retires the final line of a walk, and a fresh command from the requester. The bench provokes this by holding acknowledge high and presenting a second single-line command in the very cycle its predecessor's only request is acknowledged. A second case presents commands in the middle of long walks under an irregular acknowledge pattern. The reference model treats the stall seen before that edge as deciding the command's fate. It therefore expects the command to vanish: no extra request, no error pulse, and stall falling on schedule.

// File: rtl/cme_pkg.sv
package cme_pkg;
  typedef enum logic [2:0] {
    OP_CLN_START = 3'd0,
    OP_CLN_END   = 3'd1,
    OP_INV_START = 3'd2,
    OP_INV_END   = 3'd3,
    OP_LINE_CLN  = 3'd4,
    OP_LINE_INV  = 3'd5,
    OP_LINE_CI   = 3'd6,
    OP_INV_ALL   = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    K_CLEAN     = 2'd0,
    K_INV       = 2'd1,
    K_CLEAN_INV = 2'd2,
    K_INV_IDX   = 2'd3
  } kind_e;
endpackage

// File: rtl/cme_range_check.sv
module cme_range_check #(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 5,
  parameter int PAGE_OFF = 12,
  localparam int LINE_W  = ADDR_W - LINE_OFF
) (
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] end_i,
  output logic              ok_o,
  output logic [LINE_W-1:0] first_o,
  output logic [LINE_W-1:0] last_o
);
  logic [LINE_W:0] first_ext;
  logic            same_page;
  logic            ordered;

  // first line base at or above start; extra bit catches wrap at top of space
  assign first_ext = {1'b0, start_i[ADDR_W-1:LINE_OFF]} +
                     (LINE_W+1)'(|start_i[LINE_OFF-1:0]);
  assign last_o    = end_i[ADDR_W-1:LINE_OFF];
  assign first_o   = first_ext[LINE_W-1:0];
  assign same_page = start_i[ADDR_W-1:PAGE_OFF] == end_i[ADDR_W-1:PAGE_OFF];
  assign ordered   = end_i >= start_i;
  assign ok_o      = ordered && same_page && (first_ext <= {1'b0, last_o});
endmodule

// File: rtl/cme_walker.sv
module cme_walker #(
  parameter int LINE_W = 27,
  parameter int PG_W   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [1:0]        kind_i,
  input  logic [LINE_W-1:0] first_i,
  input  logic [LINE_W-1:0] last_i,
  input  logic              ack_i,
  output logic              busy_o,
  output logic [1:0]        kind_o,
  output logic [LINE_W-1:0] line_o
);
  logic [LINE_W-1:0] cur_q, last_q;
  logic [1:0]        kind_q;
  logic              busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      last_q <= '0;
      kind_q <= '0;
    end else if (launch_i) begin
      busy_q <= 1'b1;
      cur_q  <= first_i;
      last_q <= last_i;
      kind_q <= kind_i;
    end else if (busy_q && ack_i) begin
      if (cur_q == last_q) busy_q <= 1'b0;
      else                 cur_q  <= cur_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign kind_o = kind_q;
  assign line_o = cur_q;

  // R5
  hold_until_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !ack_i |=> busy_q && $stable(cur_q) && $stable(kind_q));

  // R3
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && ack_i && (cur_q != last_q) |=> busy_q && (cur_q == $past(cur_q) + 1'b1));

  // R8
  same_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (kind_q != cme_pkg::K_INV_IDX) |-> cur_q[LINE_W-1:PG_W] == last_q[LINE_W-1:PG_W]);

  // R9
  launch_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> !busy_q);
endmodule

// File: rtl/cme_engine.sv
module cme_engine #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int NUM_SETS   = 16,
  parameter int NUM_WAYS   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  output logic              stall_o,
  output logic              err_o,
  output logic              tag_req_o,
  output logic [1:0]        tag_kind_o,
  output logic [ADDR_W-1:0] tag_addr_o,
  input  logic              tag_ack_i
);
  import cme_pkg::*;

  localparam int LINE_OFF = $clog2(LINE_BYTES);
  localparam int PAGE_OFF = $clog2(PAGE_BYTES);
  localparam int LINE_W   = ADDR_W - LINE_OFF;
  localparam int PG_W     = PAGE_OFF - LINE_OFF;
  localparam int NUM_IDX  = NUM_SETS * NUM_WAYS;

  op_e               op;
  logic              busy, accept, launch, bad, rc_ok, err_q;
  logic [ADDR_W-1:0] cln_start_q, inv_start_q, start_sel;
  logic [LINE_W-1:0] rc_first, rc_last, first, last, wline;
  logic [1:0]        kind, wkind;

  assign op        = op_e'(cmd_op_i);
  assign accept    = cmd_valid_i && !busy;
  assign start_sel = (op == OP_INV_END) ? inv_start_q : cln_start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cln_start_q <= '0;
      inv_start_q <= '0;
      err_q       <= 1'b0;
    end else begin
      if (accept && op == OP_CLN_START) cln_start_q <= cmd_addr_i;
      if (accept && op == OP_INV_START) inv_start_q <= cmd_addr_i;
      err_q <= accept && bad;
    end
  end

  cme_range_check #(
    .ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF), .PAGE_OFF(PAGE_OFF)
  ) u_range_check (
    .start_i(start_sel),
    .end_i  (cmd_addr_i),
    .ok_o   (rc_ok),
    .first_o(rc_first),
    .last_o (rc_last)
  );

  always_comb begin
    launch = 1'b0;
    bad    = 1'b0;
    kind   = K_CLEAN;
    first  = cmd_addr_i[ADDR_W-1:LINE_OFF];
    last   = cmd_addr_i[ADDR_W-1:LINE_OFF];
    unique case (op)
      OP_CLN_END, OP_INV_END: begin
        kind   = (op == OP_INV_END) ? K_INV : K_CLEAN;
        first  = rc_first;
        last   = rc_last;
        launch = rc_ok;
        bad    = !rc_ok;
      end
      OP_LINE_CLN: begin kind = K_CLEAN;     launch = 1'b1; end
      OP_LINE_INV: begin kind = K_INV;       launch = 1'b1; end
      OP_LINE_CI:  begin kind = K_CLEAN_INV; launch = 1'b1; end
      OP_INV_ALL: begin
        kind   = K_INV_IDX;
        first  = '0;
        last   = LINE_W'(NUM_IDX - 1);
        launch = 1'b1;
      end
      default: ;
    endcase
  end

  cme_walker #(.LINE_W(LINE_W), .PG_W(PG_W)) u_walker (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(accept && launch),
    .kind_i  (kind),
    .first_i (first),
    .last_i  (last),
    .ack_i   (tag_ack_i),
    .busy_o  (busy),
    .kind_o  (wkind),
    .line_o  (wline)
  );

  assign stall_o    = busy;
  assign tag_req_o  = busy;
  assign tag_kind_o = wkind;
  assign tag_addr_o = (wkind == K_INV_IDX) ? ADDR_W'(wline) : {wline, {LINE_OFF{1'b0}}};
  assign err_o      = err_q;

  // R8
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !stall_o && !tag_req_o);

  // R9
  busy_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o && cmd_valid_i |=> !err_o);

  // R4
  rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> $past(cmd_valid_i));
endmodule

// File: tb/cme_engine_tb.sv
`timescale 1ns/1ps
module cme_engine_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [2:0]  cmd_op_i = '0;
  logic [31:0] cmd_addr_i = '0;
  logic        tag_ack_i = 1'b0;
  logic        stall_o, err_o, tag_req_o;
  logic [1:0]  tag_kind_o;
  logic [31:0] tag_addr_o;

  always #2 clk = ~clk;

  cme_engine u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cmd_addr_i(cmd_addr_i), .stall_o(stall_o), .err_o(err_o), .tag_req_o(tag_req_o),
    .tag_kind_o(tag_kind_o), .tag_addr_o(tag_addr_o), .tag_ack_i(tag_ack_i)
  );

  int          checks = 0, errors = 0, cyc = 0;
  string       tag = "R1";
  logic [33:0] q[$];
  logic        exp_err = 1'b0;
  logic [31:0] m_cstart = '0, m_istart = '0;
  logic        ack_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic        comparing = 1'b0;

  task automatic chk(bit ok, string r, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic push_range(logic [1:0] k, logic [31:0] s, logic [31:0] e);
    longint first, last;
    if (e < s || s[31:12] != e[31:12]) exp_err = 1'b1;
    else begin
      first = (longint'(s) + 31) & ~longint'(31);
      last  = longint'(e) & ~longint'(31);
      if (first > last) exp_err = 1'b1;
      else for (longint a = first; a <= last; a += 32) q.push_back({k, a[31:0]});
    end
  endtask

  // reference model: state before the edge decides acceptance
  always @(posedge clk) begin
    if (!rst_ni) begin
      q.delete(); exp_err = 1'b0; m_cstart = '0; m_istart = '0;
    end else begin
      automatic bit busy_pre = q.size() != 0;
      exp_err = 1'b0;
      if (busy_pre && tag_ack_i) void'(q.pop_front());
      if (cmd_valid_i && !busy_pre) begin
        case (cmd_op_i)
          3'd0: m_cstart = cmd_addr_i;
          3'd2: m_istart = cmd_addr_i;
          3'd1: push_range(2'd0, m_cstart, cmd_addr_i);
          3'd3: push_range(2'd1, m_istart, cmd_addr_i);
          3'd4: q.push_back({2'd0, cmd_addr_i & ~32'h1F});
          3'd5: q.push_back({2'd1, cmd_addr_i & ~32'h1F});
          3'd6: q.push_back({2'd2, cmd_addr_i & ~32'h1F});
          default: for (int i = 0; i < 64; i++) q.push_back({2'd3, 32'(i)});
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (comparing) begin
      chk(stall_o == (q.size() != 0), "R4", "stall", stall_o, q.size() != 0);
      chk(tag_req_o == (q.size() != 0), "R4", "req", tag_req_o, q.size() != 0);
      if (q.size() != 0 && tag_req_o) begin
        chk(tag_kind_o == q[0][33:32], tag, "kind", tag_kind_o, q[0][33:32]);
        chk(tag_addr_o == q[0][31:0], tag, "addr", tag_addr_o, q[0][31:0]);
      end
      chk(err_o == exp_err, "R8", "err", err_o, exp_err);
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tag_ack_i = ack_mode ? lfsr[0] : 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic send(logic [2:0] op, logic [31:0] a);
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_addr_i = a;
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (q.size() != 0 && n < 5000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!stall_o && !tag_req_o && !err_o, "R1", "reset outputs",
        {stall_o, tag_req_o, err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!stall_o && !tag_req_o && !err_o, "R1", "after release",
        {stall_o, tag_req_o, err_o}, 0);
    comparing = 1'b1;

    // R2: start alone is silent
    tag = "R2"; send(3'd0, 32'h1000); repeat (4) @(negedge clk);
    send(3'd2, 32'h2040); repeat (4) @(negedge clk);
    // R3: clean range, inclusive ends
    tag = "R3"; send(3'd1, 32'h1060); wait_idle();
    // R3: separate start registers
    send(3'd1, 32'h10A0); wait_idle();
    send(3'd3, 32'h20C0); wait_idle();
    // R3: unaligned start rounds up
    send(3'd0, 32'h3005); send(3'd1, 32'h3047); wait_idle();
    // R3: single-line window, end == start
    send(3'd2, 32'h3800); send(3'd3, 32'h3800); wait_idle();
    // R5: irregular acknowledge over a whole page
    ack_mode = 1'b1; tag = "R5";
    send(3'd2, 32'h6000); send(3'd3, 32'h6FE0); wait_idle();
    // R6: single-line kinds
    tag = "R6";
    send(3'd4, 32'h4567); wait_idle();
    send(3'd5, 32'h4567); wait_idle();
    send(3'd6, 32'h459F); wait_idle();
    // R7: invalidate all
    tag = "R7"; send(3'd7, 32'h0); wait_idle();
    // R8: rejections
    tag = "R8"; ack_mode = 1'b0;
    send(3'd0, 32'h5100); send(3'd1, 32'h50E0); wait_idle();
    send(3'd0, 32'h1FE0); send(3'd1, 32'h2000); wait_idle();
    send(3'd2, 32'h5021); send(3'd3, 32'h503F); wait_idle();
    send(3'd2, 32'hFFFFFFE1); send(3'd3, 32'hFFFFFFFF); wait_idle();
    // R9: command in same cycle as final acknowledge
    tag = "R9";
    @(negedge clk); cmd_valid_i = 1'b1; cmd_op_i = 3'd4; cmd_addr_i = 32'h7000;
    @(negedge clk); cmd_op_i = 3'd5; cmd_addr_i = 32'h7100;
    @(negedge clk); cmd_valid_i = 1'b0;
    wait_idle();
    // R9: commands mid-walk
    ack_mode = 1'b1;
    send(3'd0, 32'h8000); send(3'd1, 32'h83E0);
    send(3'd3, 32'h8100); send(3'd0, 32'h9000); send(3'd7, 32'h0);
    wait_idle();
    // clean start must still be 0x8000
    send(3'd1, 32'h8020); wait_idle();
    comparing = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule